// File: doc/BRIEF.md
# Write-Only I2C Control Slave

This block is a two-wire serial slave that only accepts write transfers. It runs entirely in the system clock domain. It oversamples the clock and data lines, cleans them up and finds the bus conditions: start, stop and clock edges. It then shifts in an address byte and compares it against a 7-bit chip address. The lowest of those address bits is taken from a strap input, so two copies of the block can share one bus.

When the address and the write direction match, the block pulls SDA low for every acknowledge clock. It accepts an unbounded stream of data bytes until a stop condition arrives. Each completed byte is handed to the surrounding control logic as an 8-bit value with a single-cycle strobe.

Read transfers, clock stretching, 10-bit addressing and general call are not handled. An unmatched or read-direction address makes the block go quiet until the next start condition.

Top module: `ctl_i2c_wr_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A stop returns the block to idle, and a byte cut short by the stop produces no strobe.
- R2: The block acknowledges an address byte equal to {6'b100001, addr_sel_i, 1'b0}, sent MSB first. The acknowledge is SDA held low for the whole ninth clock.
- R3: If the address byte has any other value, including the read direction (LSB = 1), the block drives no acknowledge. It then gives no strobe and no acknowledge for any byte until the next start.
- R4: Data bits are sampled on SCL rising edges, MSB first. Each full byte is placed on data_o with data_valid_o high for exactly one clock, and the byte is acknowledged.
- R5: After a matched address, any number of data bytes is accepted in the same transfer until a stop.
- R6: sda_oe_o is released on the SCL falling edge that ends the acknowledge clock.
- R7: A repeated start in mid-byte discards the partial byte without a strobe and restarts address matching.
- R8: After reset, sda_oe_o = 0, data_valid_o = 0 and data_o = 8'h00.
- R9: sda_oe_o changes only while the filtered SCL is low.
- R10: An SCL pulse that lasts a single system clock is ignored. A 3-sample majority filter after a two-flop synchronizer removes it, so it adds no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16x the bit rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired bus value) |
| addr_sel_i | input | 1 | Strap setting the address LSB |
| sda_oe_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| data_o | output | 8 | Last received data byte |
| data_valid_o | output | 1 | One-cycle strobe for a new data_o |

## Verification
The hardest states to reach from the ports are the ones where traffic arrives in an unusual place. One case is a byte cut off partway by a repeated start or a stop. Another is bytes that look like a matching address but arrive after a mismatch, with no new start in between. The bench reaches both with bit-level tasks that send only a chosen number of bits and then emit a condition. It then observes the strobe count and the acknowledge slot. A near-exhaustive sweep covers every 7-bit address with both strap levels, and a single long transfer carries all 256 data values.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_DATA,
    ST_DACK,
    ST_SKIP
  } state_e;
endpackage

// File: rtl/ctl_i2c_line_filter.sv
module ctl_i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_TAPS   = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_TAPS-1:0]   hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[FILT_TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= ($countones(hist_q) > (FILT_TAPS / 2));
    end
  end
endmodule

// File: rtl/ctl_i2c_bus_events.sv
module ctl_i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/ctl_i2c_wr_engine.sv
module ctl_i2c_wr_engine
  import ctl_i2c_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b100001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_valid_o
);
  state_e            st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              full, match;

  assign full  = (cnt_q == CNT_W'(BYTE_W));
  assign match = (sh_q == {ADDR_HI, addr_sel_i, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q         <= ST_IDLE;
      cnt_q        <= '0;
      sh_q         <= '0;
      sda_oe_o     <= 1'b0;
      data_o       <= '0;
      data_valid_o <= 1'b0;
    end else begin
      data_valid_o <= 1'b0;
      if (stop_i) begin
        st_q     <= ST_IDLE;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else if (start_i) begin
        st_q     <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          ST_ADDR, ST_DATA: begin
            if (scl_rise_i && !full) begin
              sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && full) begin
              cnt_q <= '0;
              if (st_q == ST_DATA) begin
                data_o       <= sh_q;
                data_valid_o <= 1'b1;
                sda_oe_o     <= 1'b1;
                st_q         <= ST_DACK;
              end else if (match) begin
                sda_oe_o <= 1'b1;
                st_q     <= ST_AACK;
              end else begin
                st_q <= ST_SKIP;
              end
            end
          end
          ST_AACK, ST_DACK: begin
            if (scl_fall_i) begin
              sda_oe_o <= 1'b0;
              st_q     <= ST_DATA;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctl_i2c_wr_slave.sv
module ctl_i2c_wr_slave
  import ctl_i2c_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_TAPS   = 3,
  parameter logic [5:0] ADDR_HI     = 6'b100001
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_valid_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic scl_f, sda_f;
  logic start_evt, stop_evt, scl_rise, scl_fall;

  assign raw   = {sda_i, scl_i};
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    ctl_i2c_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_TAPS  (FILT_TAPS)
    ) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  ctl_i2c_bus_events u_evt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .start_o   (start_evt),
    .stop_o    (stop_evt),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  ctl_i2c_wr_engine #(.ADDR_HI(ADDR_HI)) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_evt),
    .stop_i      (stop_evt),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .sda_i       (sda_f),
    .addr_sel_i  (addr_sel_i),
    .sda_oe_o    (sda_oe_o),
    .data_o      (data_o),
    .data_valid_o(data_valid_o)
  );
endmodule

// File: rtl/ctl_i2c_wr_slave_chk.sv
module ctl_i2c_wr_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_f,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       sda_oe_o,
  input logic [7:0] data_o,
  input logic       data_valid_o
);
  a_r4_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |=> !data_valid_o);

  a_r4_valid_acks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_valid_o |-> $rose(sda_oe_o));

  a_r4_data_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_valid_o |-> $stable(data_o));

  a_r1_stop_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_evt |=> (!sda_oe_o && !data_valid_o));

  a_r7_start_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_evt |=> (!sda_oe_o && !data_valid_o));

  a_r9_oe_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> !scl_f);
endmodule

bind ctl_i2c_wr_slave ctl_i2c_wr_slave_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_f       (scl_f),
  .start_evt   (start_evt),
  .stop_evt    (stop_evt),
  .sda_oe_o    (sda_oe_o),
  .data_o      (data_o),
  .data_valid_o(data_valid_o)
);

// File: tb/ctl_i2c_wr_slave_tb_top.sv
module ctl_i2c_wr_slave_tb_top;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
  logic sda_oe, dvalid;
  logic [7:0] dout;
  wire sda_bus = sda_m & ~sda_oe;

  int n_tests = 0, n_fail = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last = 8'h00;

  always #2 clk = ~clk;

  ctl_i2c_wr_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .addr_sel_i(addr_sel), .sda_oe_o(sda_oe), .data_o(dout), .data_valid_o(dvalid)
  );

  always @(negedge clk) if (rst_n && dvalid) begin
    rx_cnt++;
    rx_last = dout;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    w(T); sda_m = 1'b0; w(T); scl = 1'b0;
  endtask

  task automatic do_rstart();
    w(2); sda_m = 1'b1; w(T-2); scl = 1'b1; w(T); sda_m = 1'b0; w(T); scl = 1'b0;
  endtask

  task automatic do_stop();
    w(2); sda_m = 1'b0; w(T-2); scl = 1'b1; w(T); sda_m = 1'b1; w(T);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      w(2); sda_m = b[i];
      if (glitch && i == 4) begin
        w(2); scl = 1'b1; w(1); scl = 1'b0; w(T-5);
      end else w(T-2);
      scl = 1'b1; w(T); scl = 1'b0;
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack, output bit rel);
    send_bits(b, 8, glitch);
    w(2); sda_m = 1'b1; w(T-2); scl = 1'b1; w(T/2);
    ack = (sda_bus == 1'b0);
    w(T/2); scl = 1'b0; w(7);
    rel = (sda_oe == 1'b0);
  endtask

  initial begin : watchdog
    repeat (195000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    bit ack, rel, exp;
    int c0;
    logic [7:0] ab;
    w(4); rst_n = 1'b1; w(4);
    // R8 reset state
    chk(sda_oe == 0 && dvalid == 0 && dout == 8'h00, "R8 reset", {sda_oe, dvalid, dout}, 0);

    // R2/R3 address sweep over both strap levels
    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      for (int a = 0; a < 128; a++) begin
        exp = (a[6:0] == {6'b100001, s[0]});
        c0 = rx_cnt;
        do_start();
        send_byte({a[6:0], 1'b0}, 1'b0, ack, rel);
        chk(ack == exp, exp ? "R2 addr ack" : "R3 addr nack", ack, exp);
        send_byte(8'hA5 ^ a[7:0], 1'b0, ack, rel);
        chk(ack == exp && (rx_cnt - c0) == int'(exp), "R3/R4 byte after addr", rx_cnt - c0, exp);
        do_stop();
      end
      // R3 read direction refused
      c0 = rx_cnt;
      do_start();
      send_byte({6'b100001, s[0], 1'b1}, 1'b0, ack, rel);
      chk(!ack, "R3 read dir nack", ack, 0);
      send_byte(8'h11, 1'b0, ack, rel);
      chk(!ack && rx_cnt == c0, "R3 read dir ignored", rx_cnt - c0, 0);
      do_stop();
    end

    // R5/R4/R6 one long transfer carrying all byte values
    addr_sel = 1'b1;
    do_start();
    send_byte(8'b1000_0110, 1'b0, ack, rel);
    chk(ack && rel, "R2 long addr", {ack, rel}, 3);
    for (int b = 0; b < 256; b++) begin
      c0 = rx_cnt;
      send_byte(b[7:0], 1'b0, ack, rel);
      chk(ack && rx_cnt == c0 + 1 && rx_last == b[7:0], "R4/R5 data byte", rx_last, b);
      chk(rel, "R6 ack release", sda_oe, 0);
    end
    do_stop();

    // R3 ignored until START, even a matching pattern
    addr_sel = 1'b0;
    ab = 8'b1000_0100;
    c0 = rx_cnt;
    do_start();
    send_byte(8'h42, 1'b0, ack, rel);
    send_byte(ab, 1'b0, ack, rel);
    chk(!ack, "R3 ignore until start", ack, 0);
    send_byte(8'h77, 1'b0, ack, rel);
    chk(!ack && rx_cnt == c0, "R3 no strobe while skipping", rx_cnt - c0, 0);
    do_rstart();
    send_byte(ab, 1'b0, ack, rel);
    chk(ack, "R3 new start rematches", ack, 1);
    do_stop();

    // R7 repeated start mid-byte
    c0 = rx_cnt;
    do_start();
    send_byte(ab, 1'b0, ack, rel);
    send_bits(8'hF0, 4, 1'b0);
    do_rstart();
    send_byte(ab, 1'b0, ack, rel);
    chk(ack, "R7 rematch after rstart", ack, 1);
    send_byte(8'h3C, 1'b0, ack, rel);
    chk(rx_cnt == c0 + 1 && rx_last == 8'h3C, "R7 partial discarded", rx_cnt - c0, 1);
    do_stop();

    // R1 stop cuts a partial byte
    c0 = rx_cnt;
    do_start();
    send_byte(ab, 1'b0, ack, rel);
    send_bits(8'hFF, 3, 1'b0);
    do_stop();
    w(10);
    chk(rx_cnt == c0 && sda_oe == 0, "R1 stop discards partial", rx_cnt - c0, 0);
    send_bits(ab, 8, 1'b0);
    w(2); sda_m = 1'b1; w(T-2); scl = 1'b1; w(T/2);
    chk(sda_bus == 1'b1, "R1 idle after stop", sda_bus, 1);
    w(T/2); scl = 1'b0; w(4); scl = 1'b1; w(T);

    // R10 single-cycle SCL glitch ignored
    c0 = rx_cnt;
    do_start();
    send_byte(ab, 1'b0, ack, rel);
    send_byte(8'h96, 1'b1, ack, rel);
    chk(ack && rx_cnt == c0 + 1 && rx_last == 8'h96, "R10 glitch filtered", rx_last, 8'h96);
    do_stop();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule